// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is a single output-compare channel for a timer. Each clock it sees the running count and the channel's compare value. It drives a registered reference level according to a 3-bit mode. Eight modes are supported. Three are event-driven and act only on a count strobe that coincides with equality: set, clear and toggle. Two are forced levels. Two are pulse-width modes that follow the count-versus-compare relation every cycle. The last mode, frozen, leaves the level alone.

A 2-bit direction select decides whether the channel acts as an output (00) or is handed over to an input-capture path. The input-capture path lies outside this block; the values are 01 direct mapping, 10 crossed mapping and 11 trigger mapping. The select can be rewritten only while the channel enable is low. While the select is not 00, the reference is held low and no compare events are raised.

All pins are plain control and status signals. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure. Every output is registered, and each output reflects the inputs present at the preceding rising clock edge.

Top module: `oc_channel`

## Requirements
- R1: After reset, ref_out is 0, cmp_event is 0 and dir_sel is 00 (output).
- R2: When sel_wr is 1 and chan_en is 0 at a clock edge, dir_sel takes sel_wdata after that edge. 00 means output; 01, 10 and 11 are input mappings.
- R3: When chan_en is 1, a sel_wr request is ignored and dir_sel keeps its value.
- R4: While dir_sel is not 00, ref_out is 0 and cmp_event is 0 after each edge, whatever the mode.
- R5: Mode 000 (frozen) leaves ref_out unchanged, even on a match.
- R6: Mode 001 sets ref_out to 1 after an edge where cnt_tick is 1 and count equals compare. Otherwise it holds.
- R7: Mode 010 clears ref_out to 0 after an edge where cnt_tick is 1 and count equals compare. Otherwise it holds.
- R8: Mode 011 inverts ref_out after each edge where cnt_tick is 1 and count equals compare. Otherwise it holds.
- R9: Mode 100 drives ref_out to 0 and mode 101 drives it to 1 after every edge, with or without cnt_tick.
- R10: Mode 110 sets ref_out after every edge to 1 if count < compare, and to 0 otherwise.
- R11: Mode 111 sets ref_out after every edge to 0 if count > compare, and to 1 otherwise.
- R12: In output direction, cmp_event is 1 for exactly the one cycle after an edge where cnt_tick is 1 and count equals compare, in every mode. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| count | input | CNT_W | Running timer count |
| compare | input | CNT_W | Channel compare value |
| mode | input | 3 | Output mode (000..111) |
| chan_en | input | 1 | Channel enable; locks the direction select when 1 |
| sel_wr | input | 1 | Request to write the direction select |
| sel_wdata | input | 2 | New direction select value |
| cnt_tick | input | 1 | Strobe marking a count update; qualifies match events |
| ref_out | output | 1 | Registered reference level |
| cmp_event | output | 1 | One-cycle compare event pulse |
| dir_sel | output | 2 | Current direction select |

## Verification
The bench builds the channel with CNT_W = 8, so random counts and compares regularly hit both extremes, 0 and 255. Compares are biased toward the current count, which makes exact equality, one-below and one-above frequent. That exercises the boundaries between the two pulse-width modes and the strobe-qualified match modes in every direction-select state.

// File: rtl/oc_pkg.sv
package oc_pkg;
  typedef enum logic [2:0] {
    OC_FROZEN = 3'b000,
    OC_SET    = 3'b001,
    OC_CLR    = 3'b010,
    OC_TOG    = 3'b011,
    OC_LOW    = 3'b100,
    OC_HIGH   = 3'b101,
    OC_PWM_A  = 3'b110,
    OC_PWM_B  = 3'b111
  } oc_mode_e;

  typedef enum logic [1:0] {
    SEL_OUT       = 2'b00,
    SEL_IN_DIRECT = 2'b01,
    SEL_IN_CROSS  = 2'b10,
    SEL_IN_TRIG   = 2'b11
  } oc_sel_e;
endpackage

// File: rtl/oc_sel_reg.sv
module oc_sel_reg
  import oc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_en,
  input  logic       wr,
  input  logic [1:0] wdata,
  output oc_sel_e    sel_q,
  output logic       is_output
);
  logic accept;
  assign accept = wr && !chan_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= SEL_OUT;
    else if (accept) sel_q <= oc_sel_e'(wdata);
  end

  assign is_output = (sel_q == SEL_OUT);

  // R3: the select is locked while the channel is enabled
  a_r3_sel_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && wr) |=> $stable(sel_q));
  // R2: an unlocked write lands
  a_r2_sel_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!chan_en && wr) |=> (sel_q == $past(wdata)));
endmodule

// File: rtl/oc_cmp.sv
module oc_cmp #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] compare,
  output logic             eq,
  output logic             lt
);
  always_comb begin
    eq = (count == compare);
    lt = (count < compare);
  end
endmodule

// File: rtl/oc_ref_gen.sv
module oc_ref_gen
  import oc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  oc_mode_e mode,
  input  logic     out_dir,
  input  logic     tick,
  input  logic     eq,
  input  logic     lt,
  output logic     ref_q,
  output logic     evt_q
);
  logic hit;
  logic ref_d;

  assign hit = tick && eq;

  always_comb begin
    ref_d = ref_q;
    if (!out_dir) begin
      ref_d = 1'b0;
    end else begin
      unique case (mode)
        OC_FROZEN: ref_d = ref_q;
        OC_SET:    ref_d = hit ? 1'b1 : ref_q;
        OC_CLR:    ref_d = hit ? 1'b0 : ref_q;
        OC_TOG:    ref_d = hit ? !ref_q : ref_q;
        OC_LOW:    ref_d = 1'b0;
        OC_HIGH:   ref_d = 1'b1;
        OC_PWM_A:  ref_d = lt;
        OC_PWM_B:  ref_d = lt || eq;
        default:   ref_d = ref_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      ref_q <= ref_d;
      evt_q <= hit && out_dir;
    end
  end

  a_r4_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_dir |=> (!ref_q && !evt_q));
  a_r5_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_dir && mode == OC_FROZEN) |=> $stable(ref_q));
  a_r6_set_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (out_dir && mode == OC_SET && hit) |=> ref_q);
  a_r7_clr_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (out_dir && mode == OC_CLR && hit) |=> !ref_q);
  a_r8_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (out_dir && mode == OC_TOG && hit) |=> (ref_q != $past(ref_q)));
  a_r9_force_low: assert property (@(posedge clk) disable iff (!rst_n)
    (out_dir && mode == OC_LOW) |=> !ref_q);
  a_r9_force_high: assert property (@(posedge clk) disable iff (!rst_n)
    (out_dir && mode == OC_HIGH) |=> ref_q);
  a_r10_pwm_a: assert property (@(posedge clk) disable iff (!rst_n)
    (out_dir && mode == OC_PWM_A) |=> (ref_q == $past(lt)));
  a_r11_pwm_b: assert property (@(posedge clk) disable iff (!rst_n)
    (out_dir && mode == OC_PWM_B && !lt && !eq) |=> !ref_q);
  a_r12_event: assert property (@(posedge clk) disable iff (!rst_n)
    (out_dir && tick && eq) |=> evt_q);
  a_r12_no_event: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && eq) |=> !evt_q);
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] compare,
  input  logic [2:0]       mode,
  input  logic             chan_en,
  input  logic             sel_wr,
  input  logic [1:0]       sel_wdata,
  input  logic             cnt_tick,
  output logic             ref_out,
  output logic             cmp_event,
  output logic [1:0]       dir_sel
);
  oc_sel_e sel_q;
  logic    out_dir;
  logic    eq, lt;

  oc_sel_reg u_sel (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .wr(sel_wr),
    .wdata(sel_wdata), .sel_q(sel_q), .is_output(out_dir)
  );

  oc_cmp #(.CNT_W(CNT_W)) u_cmp (
    .count(count), .compare(compare), .eq(eq), .lt(lt)
  );

  oc_ref_gen u_ref (
    .clk(clk), .rst_n(rst_n), .mode(oc_mode_e'(mode)), .out_dir(out_dir),
    .tick(cnt_tick), .eq(eq), .lt(lt), .ref_q(ref_out), .evt_q(cmp_event)
  );

  assign dir_sel = sel_q;

  // R1: outputs idle right after reset
  a_r1_reset_idle: assert property (@(posedge clk)
    $rose(rst_n) |-> (!ref_out && !cmp_event && dir_sel == 2'b00));
endmodule

// File: tb/oc_channel_test.sv
module oc_channel_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] count = '0, compare = '0;
  logic [2:0]   mode = 3'b000;
  logic         chan_en = 1'b0, sel_wr = 1'b0, cnt_tick = 1'b0;
  logic [1:0]   sel_wdata = 2'b00;
  logic         ref_out, cmp_event;
  logic [1:0]   dir_sel;

  int checks = 0;
  int errors = 0;
  bit m_ref = 0, m_evt = 0;
  logic [1:0] m_sel = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  oc_channel #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .count(count), .compare(compare), .mode(mode),
    .chan_en(chan_en), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .cnt_tick(cnt_tick), .ref_out(ref_out), .cmp_event(cmp_event),
    .dir_sel(dir_sel)
  );

  function automatic bit exp_ref(bit cur, logic [2:0] md, logic [1:0] sel,
                                 bit tk, logic [W-1:0] c, logic [W-1:0] k);
    bit h = tk && (c == k);
    if (sel != 2'b00) return 1'b0;
    case (md)
      3'b000: return cur;
      3'b001: return h ? 1'b1 : cur;
      3'b010: return h ? 1'b0 : cur;
      3'b011: return h ? !cur : cur;
      3'b100: return 1'b0;
      3'b101: return 1'b1;
      3'b110: return c < k;
      default: return !(c > k);
    endcase
  endfunction

  function automatic string tag(logic [1:0] sel, logic [2:0] md);
    if (sel != 2'b00) return "R4";
    case (md)
      3'b000: return "R5";
      3'b001: return "R6";
      3'b010: return "R7";
      3'b011: return "R8";
      3'b100, 3'b101: return "R9";
      3'b110: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(string req, logic [1:0] act, logic [1:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // inputs are already set away from the edge; advance one edge and compare
  task automatic step();
    logic [1:0] old_sel = m_sel;
    logic [1:0] nsel = (sel_wr && !chan_en) ? sel_wdata : m_sel;
    bit nref = exp_ref(m_ref, mode, old_sel, cnt_tick, count, compare);
    bit nevt = (old_sel == 2'b00) && cnt_tick && (count == compare);
    string t = tag(old_sel, mode);
    @(posedge clk); #1;
    m_sel = nsel; m_ref = nref; m_evt = nevt;
    check(t, {1'b0, ref_out}, {1'b0, m_ref}, "ref_out");
    check("R12", {1'b0, cmp_event}, {1'b0, m_evt}, "cmp_event");
    check(sel_wr ? (chan_en ? "R3" : "R2") : "R2", dir_sel, m_sel, "dir_sel");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 3 + 2);
    check("R1", {1'b0, ref_out}, 2'd0, "ref_out");
    check("R1", {1'b0, cmp_event}, 2'd0, "cmp_event");
    check("R1", dir_sel, 2'd0, "dir_sel");
    rst_n = 1'b1;

    // R3: locked write with channel enabled
    chan_en = 1; sel_wr = 1; sel_wdata = 2'b10; step();
    // R2: unlocked write to crossed input, then back to output
    chan_en = 0; step();
    sel_wdata = 2'b00; step();
    sel_wr = 0;
    // R9 force high, then R5 frozen across a match
    mode = 3'b101; step();
    mode = 3'b000; cnt_tick = 1; count = 8'd7; compare = 8'd7; step();
    // R8 toggle twice on match; R12 event
    mode = 3'b011; step(); step();
    // R6/R7 no change without strobe
    cnt_tick = 0; mode = 3'b010; step();
    // R10/R11 boundaries at extremes
    mode = 3'b110; count = 8'd0; compare = 8'd0; step();
    count = 8'd254; compare = 8'd255; step();
    mode = 3'b111; count = 8'd255; compare = 8'd255; step();
    count = 8'd255; compare = 8'd254; step();

    for (int i = 0; i < 3000; i++) begin
      count = W'($urandom);
      case ($urandom % 4)
        0: compare = count;
        1: compare = count + 1;
        2: compare = count - 1;
        default: compare = W'($urandom);
      endcase
      mode = 3'($urandom);
      cnt_tick = ($urandom % 2) == 0;
      chan_en = ($urandom % 3) == 0;
      sel_wr = ($urandom % 8) == 0;
      sel_wdata = (($urandom % 3) == 0) ? 2'($urandom) : 2'b00;
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule